// File: doc/BRIEF.md
# Ternary-Coded Delay-Insensitive Pipeline Stage

This block models one stage of a single-rail, three-state, delay-insensitive pipeline in which every wire carries one of three states: NULL, DATA0 or DATA1. Each wire is represented by a 2-bit code. Eight ternary input wires are captured by an input register. Two 4-input NAND gates then evaluate, the first on wires 0 to 3 and the second on wires 4 to 7. Their two ternary results are captured by an output register. Every element has hysteresis. It takes a DATA value only once all of its inputs are DATA. It returns to NULL only when all of its inputs are NULL and the element after it has asked for NULL.

The stage sits between a producer and a consumer that follow a four-phase wavefront protocol. The producer watches `ko_out`: a 1 asks for a DATA wavefront and a 0 asks for a NULL wavefront. The consumer drives `ki_in` in the same sense toward the output register. The wires of a wavefront may arrive in any order and over any number of cycles. The stage reacts only when a wavefront is complete.

Top module: `tern_di_stage`

## Requirements
- R1: Codes on every ternary wire are 2'b00 = NULL, 2'b01 = DATA0 (logic 0), 2'b10 = DATA1 (logic 1). The stage never drives 2'b11 on `out_tw` or on any internal register or gate output.
- R2: After reset both output wires are NULL (`out_tw` = 4'b0000) and `ko_out` = 1.
- R3: Output wire 0 (`out_tw[1:0]`) is the NAND of input wires 0 to 3. Output wire 1 (`out_tw[3:2]`) is the NAND of input wires 4 to 7. Input wire i is `in_tw[2i+1:2i]`.
- R4: While any input wire is still NULL, the input register loads nothing. `ko_out` stays 1 and `out_tw` stays NULL, however long the partial wavefront is held.
- R5: Take an empty stage with `ki_in` = 1. Let the last input wire become DATA before clock edge k. Then `ko_out` is 0 after edge k, `out_tw` is still NULL after edge k+1, and `out_tw` carries the result after edge k+2.
- R6: An element holding DATA keeps it until its input set is entirely NULL and its downstream request is 0. With `ki_in` = 0, a NULL wavefront whose last wire arrives before edge m raises `ko_out` after edge m and makes `out_tw` NULL after edge m+2. A partial NULL wavefront leaves `ko_out` at 0.
- R7: While `ki_in` stays 1, the output register keeps its DATA even after its inputs have all gone NULL. It goes NULL on the first edge after `ki_in` falls.
- R8: While `ki_in` is 0, the output register stays NULL even when its inputs are complete DATA. It takes the DATA on the first edge after `ki_in` rises.
- R9: The input register takes no new DATA while the output register holds DATA. `ko_out` stays 1 until the output register has returned to NULL, and falls one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; registers go to their reset code |
| in_tw | input | 16 | Eight ternary input wires, wire i at bits [2i+1:2i] |
| ki_in | input | 1 | Request from the consumer: 1 asks for DATA, 0 asks for NULL |
| ko_out | output | 1 | Request to the producer: 1 asks for DATA, 0 asks for NULL |
| out_tw | output | 4 | Two ternary output wires, wire j at bits [2j+1:2j] |

## Verification
A complete DATA wavefront shows on `ko_out` one edge after its last wire arrives, and on `out_tw` two edges after that. The NULL wavefront has the same spacing. The bench counts edges from the cycle in which it drives the final wire and samples at the falling edge that follows. Before the result is due it checks that the output is still NULL, and once it is due it checks the exact value. Partial wavefronts and the two handshake stalls on `ki_in` are held for several cycles before release. The release is then checked on the first falling edge after the edge that should act on it.

// File: rtl/tern_pkg.sv
package tern_pkg;

    typedef logic [1:0] tern_t;

    localparam tern_t T_NULL = 2'b00;
    localparam tern_t T_D0   = 2'b01;
    localparam tern_t T_D1   = 2'b10;

    function automatic logic is_data(tern_t w);
        return (w == T_D0) || (w == T_D1);
    endfunction

    function automatic logic is_null(tern_t w);
        return w == T_NULL;
    endfunction

    function automatic tern_t from_bit(logic b);
        return b ? T_D1 : T_D0;
    endfunction

    function automatic logic to_bit(tern_t w);
        return w == T_D1;
    endfunction

endpackage

// File: rtl/tern_cmpl.sv
// Hysteretic completion detector: binary trees of AND nodes over the
// "is DATA" and "is NULL" flags, followed by a held state bit.
module tern_cmpl #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] dat_in,
    input  logic [N-1:0] nul_in,
    output logic         done
);

    localparam int LVL    = (N > 1) ? $clog2(N) : 0;
    localparam int LEAVES = 1 << LVL;

    typedef struct packed {
        logic held;
    } cmpl_st_t;

    cmpl_st_t st_d, st_q;

    logic [2*LEAVES-1:1] all_dat_t;
    logic [2*LEAVES-1:1] all_nul_t;

    genvar g;
    generate
        for (g = 0; g < LEAVES; g++) begin : g_leaf
            if (g < N) begin : g_used
                assign all_dat_t[LEAVES+g] = dat_in[g];
                assign all_nul_t[LEAVES+g] = nul_in[g];
            end else begin : g_pad
                assign all_dat_t[LEAVES+g] = 1'b1;
                assign all_nul_t[LEAVES+g] = 1'b1;
            end
        end
        for (g = 1; g < LEAVES; g++) begin : g_node
            assign all_dat_t[g] = all_dat_t[2*g] & all_dat_t[2*g+1];
            assign all_nul_t[g] = all_nul_t[2*g] & all_nul_t[2*g+1];
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        done      = all_dat_t[1] | (st_q.held & ~all_nul_t[1]);
        st_d.held = done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tern_reg.sv
// Ternary register stage with per-wire hysteresis.
module tern_reg
    import tern_pkg::*;
#(
    parameter int    N       = 8,
    parameter tern_t RST_VAL = T_NULL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ki,
    input  tern_t [N-1:0]     d,
    output tern_t [N-1:0]     q,
    output logic              cd
);

    typedef struct packed {
        tern_t [N-1:0] q;
    } reg_st_t;

    reg_st_t st_d, st_q;

    logic [N-1:0] d_dat, d_nul, q_dat, q_nul;
    logic         en;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            d_dat[i] = is_data(d[i]);
            d_nul[i] = is_null(d[i]);
            q_dat[i] = is_data(st_q.q[i]);
            q_nul[i] = is_null(st_q.q[i]);
        end
    end

    tern_cmpl #(.N(N)) u_en (
        .clk(clk), .rst_n(rst_n), .dat_in(d_dat), .nul_in(d_nul), .done(en)
    );

    tern_cmpl #(.N(N)) u_cd (
        .clk(clk), .rst_n(rst_n), .dat_in(q_dat), .nul_in(q_nul), .done(cd)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (ki && en && is_null(st_q.q[i]) && is_data(d[i]))
                st_d.q[i] = d[i];
            else if (!ki && !en)
                st_d.q[i] = T_NULL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.q <= {N{RST_VAL}};
        else        st_q   <= st_d;
    end

    assign q = st_q.q;

    genvar w;
    generate
        for (w = 0; w < N; w++) begin : g_chk
            // R1
            no_illegal_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
                q[w] != 2'b11);
            // R4
            data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (q[w] != T_NULL && $past(q[w]) == T_NULL) |-> ($past(ki) && $past(en)));
            // R6
            null_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (q[w] == T_NULL && $past(q[w]) != T_NULL) |-> (!$past(ki) && !$past(en)));
            // R6
            data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(q[w]) != T_NULL && q[w] != T_NULL) |-> (q[w] == $past(q[w])));
        end
    endgenerate

endmodule

// File: rtl/tern_nand_gate.sv
// K-input ternary NAND with input-complete evaluation and gated return to NULL.
module tern_nand_gate
    import tern_pkg::*;
#(
    parameter int K = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tern_t [K-1:0] a,
    input  logic          pn,
    output tern_t         f
);

    typedef struct packed {
        tern_t f;
    } gate_st_t;

    gate_st_t st_d, st_q;

    logic [K-1:0] a_dat, a_nul, a_bit;
    logic         e;

    always_comb begin
        for (int i = 0; i < K; i++) begin
            a_dat[i] = is_data(a[i]);
            a_nul[i] = is_null(a[i]);
            a_bit[i] = to_bit(a[i]);
        end
    end

    tern_cmpl #(.N(K)) u_e (
        .clk(clk), .rst_n(rst_n), .dat_in(a_dat), .nul_in(a_nul), .done(e)
    );

    always_comb begin
        st_d = st_q;
        if (e)
            st_d.f = from_bit(~&a_bit);
        else if (!pn)
            st_d.f = T_NULL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.f <= T_NULL;
        else        st_q   <= st_d;
    end

    assign f = st_q.f;

    // R1
    no_illegal_f_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f != 2'b11);
    // R3
    eval_needs_e_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f != T_NULL && $past(f) == T_NULL) |-> $past(e));
    // R6
    null_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f == T_NULL && $past(f) != T_NULL) |-> (!$past(pn) && !$past(e)));

endmodule

// File: rtl/tern_di_stage.sv
// One delay-insensitive ternary pipeline stage:
// input register -> NAND gates per group -> output register.
module tern_di_stage
    import tern_pkg::*;
#(
    parameter int    IN_W    = 8,
    parameter int    GRP     = 4,
    parameter tern_t OUT_RST = T_NULL,
    localparam int   OUT_W   = IN_W / GRP
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*IN_W-1:0]    in_tw,
    input  logic                 ki_in,
    output logic                 ko_out,
    output logic [2*OUT_W-1:0]   out_tw
);

    tern_t [IN_W-1:0]  in_w;
    tern_t [IN_W-1:0]  ir_q;
    tern_t [OUT_W-1:0] gf;
    tern_t [OUT_W-1:0] or_q;
    logic              ir_cd, or_cd, rfd_mid;
    logic              all_in_data;

    genvar i;
    generate
        for (i = 0; i < IN_W; i++) begin : g_in
            assign in_w[i] = in_tw[2*i +: 2];
        end
    endgenerate

    always_comb begin
        all_in_data = 1'b1;
        for (int k = 0; k < IN_W; k++)
            if (!is_data(in_w[k])) all_in_data = 1'b0;
    end

    tern_reg #(.N(IN_W), .RST_VAL(T_NULL)) u_in_reg (
        .clk(clk), .rst_n(rst_n), .ki(rfd_mid), .d(in_w), .q(ir_q), .cd(ir_cd)
    );

    generate
        for (i = 0; i < OUT_W; i++) begin : g_gate
            tern_nand_gate #(.K(GRP)) u_gate (
                .clk(clk), .rst_n(rst_n), .a(ir_q[i*GRP +: GRP]),
                .pn(rfd_mid), .f(gf[i])
            );
        end
    endgenerate

    tern_reg #(.N(OUT_W), .RST_VAL(OUT_RST)) u_out_reg (
        .clk(clk), .rst_n(rst_n), .ki(ki_in), .d(gf), .q(or_q), .cd(or_cd)
    );

    assign rfd_mid = ~or_cd;
    assign ko_out  = ~ir_cd;

    generate
        for (i = 0; i < OUT_W; i++) begin : g_out
            assign out_tw[2*i +: 2] = or_q[i];
        end
    endgenerate

    // R4
    ko_fall_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ko_out) |-> $past(all_in_data));
    // R9
    ko_fall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ko_out) |-> $past(rfd_mid));
    // R8
    out_fill_needs_ki_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(or_cd) |-> $past(ki_in));

endmodule

// File: tb/tern_di_stage_bench.sv
`timescale 1ns/1ps
module tern_di_stage_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] in_tw = '0;
    logic        ki_in = 1'b1;
    logic        ko_out;
    logic [3:0]  out_tw;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tern_di_stage u_tern_di_stage (
        .clk(clk), .rst_n(rst_n), .in_tw(in_tw), .ki_in(ki_in),
        .ko_out(ko_out), .out_tw(out_tw)
    );

    function automatic logic [1:0] enc(logic b);
        return b ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [3:0] nand_ref(logic [7:0] v);
        return {enc(~&v[7:4]), enc(~&v[3:0])};
    endfunction

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_out(input string tag, input logic [3:0] exp);
        check_eq(tag, {28'd0, out_tw}, {28'd0, exp});
        check_eq("R1 no 2'b11 on outputs",
                 {30'd0, out_tw[3:2] == 2'b11, out_tw[1:0] == 2'b11}, 32'd0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // DATA wavefront; skew spreads arrivals, extra delays wire 7 further.
    task automatic data_wave(input logic [7:0] v, input bit skew, input int extra);
        int dly[8];
        int mx = 0;
        for (int i = 0; i < 8; i++) begin
            dly[i] = skew ? int'($urandom % 4) : 0;
            if (dly[i] > mx) mx = dly[i];
        end
        if (extra > 0) begin
            dly[7] = mx + extra;
            mx     = dly[7];
        end
        for (int c = 0; c <= mx; c++) begin
            @(negedge clk);
            if (c == mx && mx > 0) begin
                check_eq("R4 partial DATA keeps ko_out", {31'd0, ko_out}, 32'd1);
                check_out("R4 partial DATA keeps output NULL", 4'b0000);
            end
            for (int i = 0; i < 8; i++)
                if (dly[i] == c) in_tw[2*i +: 2] = enc(v[i]);
        end
        @(posedge clk); @(negedge clk);
        check_eq("R5 ko_out falls one edge after completion", {31'd0, ko_out}, 32'd0);
        check_out("R5 output NULL after first edge", 4'b0000);
        @(posedge clk); @(negedge clk);
        check_out("R5 output NULL after second edge", 4'b0000);
        @(posedge clk); @(negedge clk);
        check_out("R3 NAND result after third edge", nand_ref(v));
    endtask

    task automatic null_wave(input bit skew, input int extra);
        int dly[8];
        int mx = 0;
        for (int i = 0; i < 8; i++) begin
            dly[i] = skew ? int'($urandom % 4) : 0;
            if (dly[i] > mx) mx = dly[i];
        end
        if (extra > 0) begin
            dly[3] = mx + extra;
            mx     = dly[3];
        end
        for (int c = 0; c <= mx; c++) begin
            @(negedge clk);
            if (c == 0) ki_in = 1'b0;
            if (c == mx && mx > 0)
                check_eq("R6 partial NULL keeps ko_out low", {31'd0, ko_out}, 32'd0);
            for (int i = 0; i < 8; i++)
                if (dly[i] == c) in_tw[2*i +: 2] = 2'b00;
        end
        @(posedge clk); @(negedge clk);
        check_eq("R6 ko_out rises after NULL completes", {31'd0, ko_out}, 32'd1);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        check_out("R6 output NULL two edges later", 4'b0000);
        ki_in = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL R5 watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] v2;
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2 state held in reset and right after release
        check_out("R2 reset output NULL", 4'b0000);
        check_eq("R2 reset ko_out", {31'd0, ko_out}, 32'd1);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check_out("R2 output NULL after release", 4'b0000);
        check_eq("R2 ko_out after release", {31'd0, ko_out}, 32'd1);

        // Directed corner patterns
        data_wave(8'hFF, 1'b0, 0);  null_wave(1'b0, 0);
        data_wave(8'h00, 1'b0, 0);  null_wave(1'b0, 0);
        data_wave(8'h0F, 1'b0, 0);  null_wave(1'b0, 0);
        // R4 long partial DATA, R6 long partial NULL
        data_wave(8'hF7, 1'b0, 6);  null_wave(1'b0, 5);

        // R7, R9, R8 handshake stalls
        v  = 8'hEF;
        v2 = 8'hF0;
        data_wave(v, 1'b0, 0);
        in_tw = '0;                           // inputs NULL, ki_in held at 1
        repeat (5) @(posedge clk);
        @(negedge clk);
        check_out("R7 output holds DATA while ki_in high", nand_ref(v));
        check_eq("R6 input register NULL while output held", {31'd0, ko_out}, 32'd1);
        for (int i = 0; i < 8; i++) in_tw[2*i +: 2] = enc(v2[i]);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_eq("R9 no load while output holds DATA", {31'd0, ko_out}, 32'd1);
        check_out("R7 output still held", nand_ref(v));
        ki_in = 1'b0;
        @(posedge clk); @(negedge clk);
        check_out("R7 output NULL one edge after ki_in falls", 4'b0000);
        check_eq("R9 ko_out still high as output empties", {31'd0, ko_out}, 32'd1);
        @(posedge clk); @(negedge clk);
        check_eq("R9 input loads one edge after output empties", {31'd0, ko_out}, 32'd0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_out("R8 output stays NULL while ki_in low", 4'b0000);
        ki_in = 1'b1;
        @(posedge clk); @(negedge clk);
        check_out("R8 output takes DATA one edge after ki_in rises", nand_ref(v2));
        null_wave(1'b0, 0);

        // Random wavefronts with per-wire skew
        for (int n = 0; n < 16; n++) begin
            v = 8'($urandom);
            if (n % 4 == 0) v[3:0] = 4'hF;
            data_wave(v, 1'b1, 0);
            null_wave(1'b1, 0);
        end

        summary();
    end

endmodule